// File: doc/BRIEF.md
# Command-Coded Output Pin Register

This block drives an 8-pin output header from a memory-mapped AXI4-Lite slave. Software writes an argument register and then a control register. The control value chooses how the argument turns into a new pin pattern. The block can clear the pattern, load a pattern with exactly one pin set at the index given by the argument, load all zeros, or copy the argument in as a bit mask. The pattern is held in a 16-bit register, and its low 8 bits drive the pins. Software reads the whole 16-bit pattern back through a status word.

There is no start or done handshake. Every write to the control register evaluates the current control and argument values once. Writing only the argument has no effect until the control register is written again. An unknown control code keeps the held pattern.

The bus side has three state machines. The write machine has the states IDLE, ADDR_HELD, DATA_HELD and RESP. It moves from IDLE to RESP when the address and data arrive together. It moves from IDLE to ADDR_HELD or to DATA_HELD when only one of them arrives. It moves from either held state to RESP when the missing channel arrives, and from RESP back to IDLE on bready. The read machine moves from R_IDLE to R_DATA on arvalid, and from R_DATA back to R_IDLE on rready. The evaluation machine moves from EV_WAIT to EV_APPLY after a control write, and from EV_APPLY back to EV_WAIT on the next cycle. The pattern is updated in EV_APPLY.

Top module: `pin_cmd_axil`

## Requirements
- R1: After reset the pins and the 16-bit pattern are zero. The control and argument registers read as zero, and zero is not a valid command.
- R2: Control value 0x000F clears the pattern to zero.
- R3: Control value 0x000A replaces the whole pattern with a single 1 at bit position `argument`. If the argument is 8 to 15, the bit appears only in the readback and no pin goes high. If the argument is 16 or more, the pattern becomes zero.
- R4: Control value 0x0005 sets the pattern to zero whatever the argument holds.
- R5: Control value 0x0001 copies the 16-bit argument into the pattern. Pins 7..0 show argument bits 7..0.
- R6: Any other control value leaves the pattern and the pins unchanged.
- R7: Only a write transaction to the control word evaluates. A write to the argument alone leaves the pins unchanged. Writing the same control value again re-evaluates with the current argument.
- R8: Byte offsets: control 0x10, argument 0x18, pattern readback 0x20 (read-only, zero-extended to 32 bits). Control and argument read back their stored values. Any other offset reads zero. Writes to 0x20 or to any unmapped offset change nothing.
- R9: The write address and write data may arrive in either order or together. wstrb bit 0 enables register bits 7..0 and wstrb bit 1 enables bits 15..8.
- R10: bvalid and rvalid stay high until they are accepted, and rdata stays stable while rvalid waits. Every response is OKAY (2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 6 | Write address (byte) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 6 | Read address (byte) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| pins_o | output | 8 | Header output pins |

## Verification
The hardest cases to reach from the ports are those where the pins and the readback disagree or where a write must have no visible effect:
- a one-hot index of 8 to 15, which changes only the readback;
- an index of 16 or more;
- an argument write that must leave the pins alone until the control register is written again.

The stimulus reaches these cases with directed sequences: it writes the argument, checks the pins, and only then writes the control register. A seeded random phase adds three things. It mixes command codes with invalid codes. It drives the address and data channels in all three orders. It uses partial byte strobes and delays rready. A bench model predicts the pins after every transaction.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
    localparam logic [15:0] CMD_CLEAR  = 16'h000F;
    localparam logic [15:0] CMD_ONEHOT = 16'h000A;
    localparam logic [15:0] CMD_ZERO   = 16'h0005;
    localparam logic [15:0] CMD_LOAD   = 16'h0001;

    localparam int CTRL_WORD = 4;   // byte 0x10
    localparam int ARG_WORD  = 6;   // byte 0x18
    localparam int STAT_WORD = 8;   // byte 0x20

    typedef enum logic [1:0] {W_IDLE, W_ADDR_HELD, W_DATA_HELD, W_RESP} wr_state_e;
    typedef enum logic {R_IDLE, R_DATA} rd_state_e;
    typedef enum logic {EV_WAIT, EV_APPLY} ev_state_e;
endpackage

// File: rtl/pcr_axil_wr.sv
module pcr_axil_wr
    import pcr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [STRB_W-1:0] wr_strb
);
    wr_state_e state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [STRB_W-1:0] strb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            strb_q <= '0;
        end else begin
            if (awvalid && awready) addr_q <= awaddr;
            if (wvalid && wready) begin
                data_q <= wdata;
                strb_q <= wstrb;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        awready = 1'b0;
        wready  = 1'b0;
        bvalid  = 1'b0;
        wr_fire = 1'b0;
        wr_addr = addr_q;
        wr_data = data_q;
        wr_strb = strb_q;
        unique case (state_q)
            W_IDLE: begin
                awready = 1'b1;
                wready  = 1'b1;
                if (awvalid && wvalid) begin
                    wr_fire = 1'b1;
                    wr_addr = awaddr;
                    wr_data = wdata;
                    wr_strb = wstrb;
                    state_d = W_RESP;
                end else if (awvalid) begin
                    state_d = W_ADDR_HELD;
                end else if (wvalid) begin
                    state_d = W_DATA_HELD;
                end
            end
            W_ADDR_HELD: begin
                wready = 1'b1;
                if (wvalid) begin
                    wr_fire = 1'b1;
                    wr_data = wdata;
                    wr_strb = wstrb;
                    state_d = W_RESP;
                end
            end
            W_DATA_HELD: begin
                awready = 1'b1;
                if (awvalid) begin
                    wr_fire = 1'b1;
                    wr_addr = awaddr;
                    state_d = W_RESP;
                end
            end
            W_RESP: begin
                bvalid = 1'b1;
                if (bready) state_d = W_IDLE;
            end
            default: state_d = W_IDLE;
        endcase
    end

    assign bresp = 2'b00;
endmodule

// File: rtl/pcr_axil_rd.sv
module pcr_axil_rd
    import pcr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_value
);
    rd_state_e state_q, state_d;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= R_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          rdata_q <= '0;
        else if (state_q == R_IDLE && arvalid) rdata_q <= rd_value;
    end

    always_comb begin
        state_d = state_q;
        arready = 1'b0;
        rvalid  = 1'b0;
        unique case (state_q)
            R_IDLE: begin
                arready = 1'b1;
                if (arvalid) state_d = R_DATA;
            end
            R_DATA: begin
                rvalid = 1'b1;
                if (rready) state_d = R_IDLE;
            end
            default: state_d = R_IDLE;
        endcase
    end

    assign rd_addr = araddr;
    assign rdata   = rdata_q;
    assign rresp   = 2'b00;
endmodule

// File: rtl/pcr_regs.sv
module pcr_regs
    import pcr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int REG_W  = 16,
    localparam int STRB_W = DATA_W / 8,
    localparam int NBYTE  = REG_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [STRB_W-1:0] wr_strb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_value,
    input  logic [REG_W-1:0]  pattern,
    output logic [REG_W-1:0]  ctrl_q,
    output logic [REG_W-1:0]  arg_q,
    output logic              ctrl_written
);
    logic ctrl_hit, arg_hit;
    assign ctrl_hit = wr_fire && (int'(wr_addr[ADDR_W-1:2]) == CTRL_WORD);
    assign arg_hit  = wr_fire && (int'(wr_addr[ADDR_W-1:2]) == ARG_WORD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q       <= '0;
            arg_q        <= '0;
            ctrl_written <= 1'b0;
        end else begin
            ctrl_written <= ctrl_hit;
            for (int b = 0; b < NBYTE; b++) begin
                if (ctrl_hit && wr_strb[b]) ctrl_q[b*8 +: 8] <= wr_data[b*8 +: 8];
                if (arg_hit  && wr_strb[b]) arg_q[b*8 +: 8]  <= wr_data[b*8 +: 8];
            end
        end
    end

    always_comb begin
        unique case (int'(rd_addr[ADDR_W-1:2]))
            CTRL_WORD: rd_value = DATA_W'(ctrl_q);
            ARG_WORD:  rd_value = DATA_W'(arg_q);
            STAT_WORD: rd_value = DATA_W'(pattern);
            default:   rd_value = '0;
        endcase
    end
endmodule

// File: rtl/pcr_eval.sv
module pcr_eval
    import pcr_pkg::*;
#(
    parameter int REG_W = 16,
    localparam int IDX_W = $clog2(REG_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_written,
    input  logic [REG_W-1:0] ctrl,
    input  logic [REG_W-1:0] arg,
    output logic             eval_go,
    output logic [REG_W-1:0] pattern_q
);
    ev_state_e state_q, state_d;
    logic [REG_W-1:0] next_pat;
    logic             idx_in_range;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EV_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_WAIT:  if (ctrl_written) state_d = EV_APPLY;
            EV_APPLY: state_d = ctrl_written ? EV_APPLY : EV_WAIT;
            default:  state_d = EV_WAIT;
        endcase
    end

    assign eval_go      = (state_q == EV_APPLY);
    assign idx_in_range = ((arg >> IDX_W) == '0);

    always_comb begin
        if (ctrl == REG_W'(CMD_CLEAR) || ctrl == REG_W'(CMD_ZERO))
            next_pat = '0;
        else if (ctrl == REG_W'(CMD_ONEHOT))
            next_pat = idx_in_range ? (REG_W'(1) << arg[IDX_W-1:0]) : '0;
        else if (ctrl == REG_W'(CMD_LOAD))
            next_pat = arg;
        else
            next_pat = pattern_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       pattern_q <= '0;
        else if (eval_go) pattern_q <= next_pat;
    end
endmodule

// File: rtl/pin_cmd_axil.sv
module pin_cmd_axil
    import pcr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int REG_W  = 16,
    parameter int PIN_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [DATA_W-1:0]   s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    input  logic                s_wvalid,
    output logic                s_wready,
    output logic [1:0]          s_bresp,
    output logic                s_bvalid,
    input  logic                s_bready,
    input  logic [ADDR_W-1:0]   s_araddr,
    input  logic                s_arvalid,
    output logic                s_arready,
    output logic [DATA_W-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    output logic                s_rvalid,
    input  logic                s_rready,
    output logic [PIN_W-1:0]    pins_o
);
    localparam int STRB_W = DATA_W / 8;

    logic              wr_fire;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_value;
    logic [STRB_W-1:0] wr_strb;
    logic [REG_W-1:0]  ctrl_q, arg_q, pattern_q;
    logic              ctrl_written, eval_go;

    pcr_axil_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
        .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
        .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb)
    );

    pcr_axil_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
        .rd_addr(rd_addr), .rd_value(rd_value)
    );

    pcr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
        .rd_addr(rd_addr), .rd_value(rd_value), .pattern(pattern_q),
        .ctrl_q(ctrl_q), .arg_q(arg_q), .ctrl_written(ctrl_written)
    );

    pcr_eval #(.REG_W(REG_W)) u_eval (
        .clk(clk), .rst_n(rst_n),
        .ctrl_written(ctrl_written), .ctrl(ctrl_q), .arg(arg_q),
        .eval_go(eval_go), .pattern_q(pattern_q)
    );

    assign pins_o = pattern_q[PIN_W-1:0];
endmodule

// File: rtl/pcr_chk.sv
module pcr_chk
    import pcr_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int PIN_W  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(REG_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PIN_W-1:0]  pins_o,
    input logic              ctrl_written,
    input logic              eval_go,
    input logic [REG_W-1:0]  ctrl_q,
    input logic [REG_W-1:0]  arg_q,
    input logic [REG_W-1:0]  pattern_q,
    input logic              bvalid,
    input logic              bready,
    input logic [1:0]        bresp,
    input logic              rvalid,
    input logic              rready,
    input logic [DATA_W-1:0] rdata,
    input logic [1:0]        rresp
);
    logic known_cmd;
    assign known_cmd = (ctrl_q == REG_W'(CMD_CLEAR)) || (ctrl_q == REG_W'(CMD_ONEHOT)) ||
                       (ctrl_q == REG_W'(CMD_ZERO))  || (ctrl_q == REG_W'(CMD_LOAD));

    a_r7_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctrl_written) |=> $stable(pins_o));

    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_go && ctrl_q == REG_W'(CMD_CLEAR)) |=> (pattern_q == '0));

    a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_go && ctrl_q == REG_W'(CMD_ONEHOT) && (arg_q >> IDX_W) == '0)
        |=> ($countones(pattern_q) == 1));

    a_r3_onehot_range: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_go && ctrl_q == REG_W'(CMD_ONEHOT) && (arg_q >> IDX_W) != '0)
        |=> (pattern_q == '0));

    a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_go && ctrl_q == REG_W'(CMD_ZERO)) |=> (pattern_q == '0));

    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_go && ctrl_q == REG_W'(CMD_LOAD)) |=> (pattern_q == $past(arg_q)));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_go && !known_cmd) |=> $stable(pattern_q));

    a_r10_bhold: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);

    a_r10_rhold: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));

    a_r10_okay: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid || rvalid) |-> (bresp == 2'b00 && rresp == 2'b00));
endmodule

bind pin_cmd_axil pcr_chk #(.REG_W(REG_W), .PIN_W(PIN_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pins_o(pins_o),
    .ctrl_written(ctrl_written), .eval_go(eval_go),
    .ctrl_q(ctrl_q), .arg_q(arg_q), .pattern_q(pattern_q),
    .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
    .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp)
);

// File: tb/pin_cmd_axil_test.sv
module pin_cmd_axil_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  awaddr = '0, araddr = '0;
    logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, arvalid = 1'b0, rready = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic [7:0]  pins;

    int tests = 0;
    int fails = 0;
    logic [15:0] m_ctrl = '0, m_arg = '0, m_pat = '0;

    always #10 clk = ~clk;

    pin_cmd_axil uut (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .pins_o(pins)
    );

    function automatic logic [15:0] eval_cmd(logic [15:0] c, logic [15:0] a, logic [15:0] old);
        case (c)
            16'h000F, 16'h0005: return 16'h0000;
            16'h000A: return (a < 16) ? (16'h0001 << a) : 16'h0000;
            16'h0001: return a;
            default:  return old;
        endcase
    endfunction

    function automatic logic [15:0] merge(logic [15:0] old, logic [31:0] d, logic [3:0] s);
        logic [15:0] r;
        r = old;
        if (s[0]) r[7:0]  = d[7:0];
        if (s[1]) r[15:8] = d[15:8];
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // mode 0: together, 1: address first, 2: data first
    task automatic axi_write(logic [5:0] a, logic [31:0] d, logic [3:0] s, int mode);
        @(negedge clk);
        if (mode != 2) begin awaddr = a; awvalid = 1'b1; end
        if (mode != 1) begin wdata = d; wstrb = s; wvalid = 1'b1; end
        if (mode == 0) begin
            while (!(awready && wready)) @(negedge clk);
            @(negedge clk);
            awvalid = 1'b0; wvalid = 1'b0;
        end else if (mode == 1) begin
            while (!awready) @(negedge clk);
            @(negedge clk);
            awvalid = 1'b0; wdata = d; wstrb = s; wvalid = 1'b1;
            while (!wready) @(negedge clk);
            @(negedge clk);
            wvalid = 1'b0;
        end else begin
            while (!wready) @(negedge clk);
            @(negedge clk);
            wvalid = 1'b0; awaddr = a; awvalid = 1'b1;
            while (!awready) @(negedge clk);
            @(negedge clk);
            awvalid = 1'b0;
        end
        bready = 1'b1;
        while (!bvalid) @(negedge clk);
        check("R10 bresp", {30'd0, bresp}, 32'd0);
        @(negedge clk);
        bready = 1'b0;
        if (a == 6'h10) begin
            m_ctrl = merge(m_ctrl, d, s);
            m_pat  = eval_cmd(m_ctrl, m_arg, m_pat);
        end else if (a == 6'h18) begin
            m_arg = merge(m_arg, d, s);
        end
        @(negedge clk);
    endtask

    task automatic axi_read(logic [5:0] a, int delay, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        repeat (delay) @(negedge clk);
        rready = 1'b1;
        while (!rvalid) @(negedge clk);
        d = rdata;
        check("R10 rresp", {30'd0, rresp}, 32'd0);
        @(negedge clk);
        rready = 1'b0;
    endtask

    task automatic cmd(logic [15:0] arg, logic [15:0] c);
        axi_write(6'h18, {16'd0, arg}, 4'hF, 0);
        axi_write(6'h10, {16'd0, c}, 4'hF, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pins", {24'd0, pins}, 32'd0);
        axi_read(6'h20, 0, rd); check("R1 pattern", rd, 32'd0);
        axi_read(6'h10, 0, rd); check("R1 ctrl", rd, 32'd0);
        axi_read(6'h18, 0, rd); check("R1 arg", rd, 32'd0);

        // R5 mask load
        cmd(16'h0042, 16'h0001);
        check("R5 pins", {24'd0, pins}, 32'h42);
        axi_read(6'h20, 0, rd); check("R5 readback", rd, 32'd66);
        cmd(16'hA5C3, 16'h0001);
        check("R5 pins low byte", {24'd0, pins}, 32'hC3);
        axi_read(6'h20, 0, rd); check("R5 full pattern", rd, 32'hA5C3);

        // R7 argument alone does nothing; rewrite of control re-evaluates
        axi_write(6'h18, 32'h0000_0011, 4'hF, 0);
        check("R7 arg only", {24'd0, pins}, 32'hC3);
        axi_read(6'h18, 0, rd); check("R8 arg readback", rd, 32'h11);
        axi_write(6'h10, 32'h0000_0001, 4'hF, 0);
        check("R7 re-evaluate", {24'd0, pins}, 32'h11);

        // R3 one-hot
        cmd(16'd3, 16'h000A);
        check("R3 index 3", {24'd0, pins}, 32'h08);
        cmd(16'd12, 16'h000A);
        check("R3 index 12 pins", {24'd0, pins}, 32'h00);
        axi_read(6'h20, 0, rd); check("R3 index 12 readback", rd, 32'h1000);
        cmd(16'd20, 16'h000A);
        axi_read(6'h20, 0, rd); check("R3 index 20", rd, 32'h0);

        // R4 zero pattern
        cmd(16'h00FF, 16'h0001);
        cmd(16'h00FF, 16'h0005);
        check("R4 zero", {24'd0, pins}, 32'h0);

        // R2 clear
        cmd(16'h00FF, 16'h0001);
        axi_write(6'h10, 32'h0000_000F, 4'hF, 0);
        check("R2 clear", {24'd0, pins}, 32'h0);

        // R6 unknown code holds
        cmd(16'h003C, 16'h0001);
        cmd(16'h0081, 16'h0007);
        check("R6 hold", {24'd0, pins}, 32'h3C);
        axi_read(6'h10, 0, rd); check("R6 ctrl stored", rd, 32'h7);

        // R8 readback offset and unmapped offsets ignore writes, unmapped reads zero
        axi_write(6'h20, 32'hFFFF_FFFF, 4'hF, 0);
        axi_write(6'h08, 32'hFFFF_FFFF, 4'hF, 0);
        check("R8 write ignored", {24'd0, pins}, 32'h3C);
        axi_read(6'h20, 0, rd); check("R8 status kept", rd, 32'h3C);
        axi_read(6'h04, 0, rd); check("R8 unmapped read", rd, 32'h0);
        axi_read(6'h08, 0, rd); check("R8 unmapped after write", rd, 32'h0);

        // R9 channel order and strobes
        axi_write(6'h18, 32'h0000_005A, 4'hF, 1);
        axi_write(6'h10, 32'h0000_0001, 4'hF, 2);
        check("R9 split channels", {24'd0, pins}, 32'h5A);
        axi_write(6'h18, 32'h0000_7766, 4'h2, 2);
        axi_read(6'h18, 0, rd); check("R9 high strobe", rd, 32'h775A);
        axi_write(6'h10, 32'h0000_0001, 4'h1, 1);
        axi_read(6'h20, 3, rd); check("R10 delayed read", rd, 32'h775A);

        // random phase
        for (int i = 0; i < 300; i++) begin
            int sel;
            logic [15:0] a, c;
            logic [3:0] s;
            sel = int'($urandom_range(0, 5));
            a = ($urandom_range(0, 1) == 1) ? 16'($urandom_range(0, 20)) : 16'($urandom);
            case (sel)
                0: c = 16'h000F; 1: c = 16'h000A; 2: c = 16'h0005;
                3: c = 16'h0001; 4: c = 16'($urandom_range(0, 15));
                default: c = 16'($urandom);
            endcase
            s = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF;
            axi_write(6'h18, {16'd0, a}, s, int'($urandom_range(0, 2)));
            check("R7 random arg only", {24'd0, pins}, {24'd0, m_pat[7:0]});
            axi_write(6'h10, {16'd0, c}, 4'hF, int'($urandom_range(0, 2)));
            check("R5 R3 random pins", {24'd0, pins}, {24'd0, m_pat[7:0]});
            if (i % 4 == 0) begin
                axi_read(6'h20, int'($urandom_range(0, 3)), rd);
                check("R8 random readback", rd, {16'd0, m_pat});
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule